// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the address for each beat of a four-beat burst. A load strobe captures a full starting address and restarts the beat counter at zero. Each cycle in which the advance input is high moves the burst on by one beat, and the counter wraps within the group of four. The upper address bits stay at the captured value for the whole burst. Only the low two bits change, in an order that the order-select input chooses.

Two orders are available. In the interleaved order, each beat is reached by XOR-ing the starting low bits with the beat count. In the linear order, the beat count is added to the starting low bits, modulo four. The order input is decoded combinationally, so the address output follows it in the same cycle. The beat count does not depend on it.

The reset input is asserted asynchronously and active low. Its release is synchronised inside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, the beat count reads 0 and the address output reads 0.
- R2: A clock edge with the load input high captures the whole address input. From the next cycle the address output equals that address and the beat count is 0.
- R3: A clock edge with load low and advance high increments the beat count by one. The count wraps from 3 to 0.
- R4: A clock edge with both load and advance low leaves the beat count and the address output unchanged. The address input has no effect on that edge.
- R5: When load and advance are both high on the same edge, load wins and the beat count becomes 0.
- R6: With the order input high (interleaved), address bits [1:0] equal the captured start bits XOR the beat count. For example, start 1 gives 1, 0, 3, 2.
- R7: With the order input low (linear), address bits [1:0] equal the captured start bits plus the beat count, modulo 4. For example, start 1 gives 1, 2, 3, 0.
- R8: Address bits above bit 1 hold their captured value on every edge without a load.
- R9: A change of the order input alters address bits [1:0] in the same cycle and leaves the beat count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously inside the block |
| load_i | input | 1 | Starts a burst and captures addr_i |
| adv_i | input | 1 | Advances the burst by one beat |
| order_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | ADDR_W (17) | Starting address of a burst |
| addr_o | output | ADDR_W (17) | Address of the current beat |
| beat_o | output | BEAT_W (2) | Current beat count |

## Verification
The assertions take for granted that load, advance and order are driven to known levels once reset has been released. The address input only has to be known on edges where load is high. The one-cycle properties also rely on reset staying inactive for the cycle they span, because the reset synchroniser releases two edges after rst_n rises. The stimulus drives every input on the falling edge and keeps all of them at defined values from time zero. After each rst_n release it waits several cycles before the first load, so every property sees a clean history.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load) base_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  // upper bits only change on a load
  assert_upper_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q[ADDR_W-1:BEAT_W]));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> base_q == $past(addr_in));
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat_q
);
  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  // load takes priority and restarts; advance steps and wraps naturally
  always_comb begin
    beat_en = load | adv;
    beat_d  = load ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assert_load_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat_q == '0);

  assert_advance_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> beat_q == $past(beat_q) + 1'b1);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lo_xor;
  logic [BEAT_W-1:0] lo_sum;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign lo_xor[b] = start[b] ^ beat[b];
  end

  assign lo_sum = start + beat;

  always_comb begin
    case (order)
      ORD_INTERLEAVE: low = lo_xor;
      default:        low = lo_sum;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] low_bits;
  order_e            order_sel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign order_sel = order_e'(order_i);

  burst_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load_i),
    .addr_in (addr_i),
    .base_q  (base_q)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (load_i),
    .adv    (adv_i),
    .beat_q (beat_o)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order (order_sel),
    .start (base_q[BEAT_W-1:0]),
    .beat  (beat_o),
    .low   (low_bits)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_bits};

  // first beat is the start address in either order
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_i |=> addr_o == $past(addr_i));

  assert_upper_out_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_int_n |-> (beat_o == '0 && addr_o == '0));

  assert_idle_addr_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!load_i && !adv_i && $stable(order_i)) |=> $stable(addr_o));

  initial begin
    if (UP_W < 1) $error("ADDR_W must exceed BEAT_W");
  end
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 17;
  localparam int BW = 2;
  localparam int VW = 3 + AW + BW + AW;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0, adv_i = 1'b0, order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [BW-1:0] beat_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  // {load, adv, order, addr_in, exp_beat, exp_addr}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b101, 17'h1ABC5, 2'd0, 17'h1ABC5}, // R2 load, interleave
    {3'b011, 17'h00000, 2'd1, 17'h1ABC4}, // R6
    {3'b011, 17'h00000, 2'd2, 17'h1ABC7}, // R6
    {3'b011, 17'h00000, 2'd3, 17'h1ABC6}, // R6
    {3'b011, 17'h00000, 2'd0, 17'h1ABC5}, // R3 wrap
    {3'b001, 17'h0FFFF, 2'd0, 17'h1ABC5}, // R4 idle
    {3'b100, 17'h0F3F2, 2'd0, 17'h0F3F2}, // R2 load, linear
    {3'b010, 17'h00000, 2'd1, 17'h0F3F3}, // R7
    {3'b010, 17'h00000, 2'd2, 17'h0F3F0}, // R7 wrap of low bits
    {3'b000, 17'h1FFFF, 2'd2, 17'h0F3F0}, // R4 R8 idle ignores addr
    {3'b010, 17'h00000, 2'd3, 17'h0F3F1}, // R7
    {3'b111, 17'h00003, 2'd0, 17'h00003}, // R5 load beats advance
    {3'b011, 17'h1FFFF, 2'd1, 17'h00002}, // R6 R8
    {3'b000, 17'h00000, 2'd1, 17'h00000}, // R9 order switch
    {3'b010, 17'h00000, 2'd2, 17'h00001}, // R7
    {3'b011, 17'h00000, 2'd3, 17'h00000}  // R6
  };

  task automatic check(input string req, input logic [BW-1:0] eb,
                       input logic [AW-1:0] ea);
    n_chk++;
    if (beat_o !== eb || addr_o !== ea) begin
      n_bad++;
      $display("FAIL %s: beat=%0d addr=%05h expected beat=%0d addr=%05h",
               req, beat_o, addr_o, eb, ea);
    end
  endtask

  task automatic step(input logic l, input logic a, input logic o,
                      input logic [AW-1:0] ad);
    @(negedge clk);
    load_i = l; adv_i = a; order_i = o; addr_i = ad;
    @(posedge clk);
    #2;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load_i = 1'b0; adv_i = 1'b0;
    end
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [BW-1:0] exp_lo;
    repeat (3) @(posedge clk);
    #2;
    check("R1 in reset", '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(4);
    #2;
    check("R1 after release", '0, '0);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][VW-1], VEC[v][VW-2], VEC[v][VW-3], VEC[v][VW-4 -: AW]);
      check($sformatf("table row %0d", v), VEC[v][AW+BW-1 -: BW], VEC[v][AW-1:0]);
    end

    // R6 R7: every start position in both orders
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b1, 1'b0, o[0], {15'h2D4B, s[1:0]});
        for (int b = 0; b < 4; b++) begin
          exp_lo = o[0] ? (s[1:0] ^ b[1:0]) : (s[1:0] + b[1:0]);
          check(o[0] ? "R6 sweep" : "R7 sweep", b[1:0], {15'h2D4B, exp_lo});
          if (b < 3) step(1'b0, 1'b1, o[0], '0);
        end
      end
    end

    // R1: asynchronous reset in mid-burst
    step(1'b1, 1'b0, 1'b1, 17'h15555);
    step(1'b0, 1'b1, 1'b1, '0);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear", '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(4);
    #2;
    check("R1 cleared after release", '0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule